// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the digital control core of a 14-bit sampling converter. A rising edge on the convert-start input begins a conversion. The block raises a hold flag for the track/hold stage. At the same edge it samples a clock-select pin, which decides whether the conversion is timed by an internal divided clock or by falling edges that arrive later on that same pin. The block then counts exactly sixteen conversion-clock falls. On the fifteenth fall it copies the 14-bit two's-complement code on its sample input into an output register.

A single status output serves two purposes. The level of the convert-start input at the moment of the load picks its behaviour. If start is low, the output acts as a busy flag. If start is high, it gives an end-of-conversion pulse. The output register reaches the data bus only while both chip-select and read are low. Otherwise the bus is marked undriven through an enable output. Both asynchronous inputs pass through two-flop synchronisers before their edges are used.

The controller has four states:
- S_IDLE (waiting for a start edge).
- S_GUARD (external clock selected; a settling window during which falls on the pin are ignored).
- S_CONV (counting falls up to the load).
- S_TAIL (after the load, waiting for the sixteenth fall).

Its transitions are:
- IDLE to GUARD on an accepted start edge with the pin high.
- IDLE to CONV on an accepted start edge with the pin low.
- GUARD to CONV when the window expires.
- CONV to TAIL on the fifteenth fall, which is also when the result is loaded.
- TAIL to IDLE on the sixteenth fall.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, a rising edge on `cnv_start` raises `hold` three system-clock edges later. `hold` stays high until the sixteenth conversion-clock fall.
- R2: The synchronised level of `ckpin` at the start edge selects the clock source. Low selects the internal clock, with period INT_DIV system cycles. High selects falling edges on `ckpin`; with no such falls the conversion does not advance.
- R3: Each conversion counts exactly 16 conversion-clock falls. With the internal clock at INT_DIV=4, `hold` is high for exactly 64 system cycles.
- R4: The value on `sample_code` at the fifteenth fall is loaded into the output register. Changes to `sample_code` before that fall are used; changes after it are not.
- R5: Busy mode applies when `cnv_start` is low at the load. `stat` is high from the start until the load (60 cycles with the internal clock), then low, and it stays low in idle.
- R6: End-of-conversion mode applies when `cnv_start` is high at the load. `stat` goes low for one conversion-clock period (4 cycles with the internal clock) after the load, then returns high and stays high in idle.
- R7: While the internal clock is selected, toggling `ckpin` during a conversion does not change its length or its result.
- R8: With the external clock, falls on `ckpin` within GUARD_CYC system cycles of the accepted start edge are not counted.
- R9: A start edge that arrives while a conversion is in progress is ignored. The current conversion keeps its length, and no second conversion follows.
- R10: `dout_oe` is 1 and `dout` shows the output register only when `cs_n`=0 and `rd_n`=0. Otherwise `dout_oe`=0 and `dout`=0.
- R11: Codes are 14-bit two's complement and are stored unaltered. Bit 13 is the sign. 14'h1FFF is the most positive code, 14'h2000 the most negative, and 14'h0000 is mid-scale.
- R12: During and after reset, `hold`=0, `stat`=0, and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_start | input | 1 | Convert-start input; its rising edge starts a conversion and its level at load picks the status mode |
| ckpin | input | 1 | Clock-select level at start; external conversion clock afterwards |
| sample_code | input | 14 | Raw two's-complement code from the converter core |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hold | output | 1 | Track/hold in hold mode |
| stat | output | 1 | Dual-purpose busy / end-of-conversion status |
| dout | output | 14 | Data bus value (0 when not enabled) |
| dout_oe | output | 1 | Data bus drive enable |

## Verification
A miscounted fall counter shows at once as a `hold` window that is not 64 cycles long, and as a `stat` fall that is not 60 cycles after the start. A wrong load index shows on the next bus read, as a stale or early code. A source-select or guard fault appears as an external conversion that finishes without falls on the pin, or that loads one fall early. The early load is visible within a few cycles of the fourteenth fall. A status mode latched at the wrong moment appears as the wrong idle `stat` level as soon as the conversion ends.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_GUARD = 2'd1,
        S_CONV  = 2'd2,
        S_TAIL  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic edge_det
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign level = chain_q[STAGES-1];

    generate
        if (FALLING) begin : g_fall
            assign edge_det = ~chain_q[STAGES-1] & last_q;
        end else begin : g_rise
            assign edge_det = chain_q[STAGES-1] & ~last_q;
        end
    endgenerate
endmodule

// File: rtl/adc_int_div.sv
module adc_int_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (restart)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CONV_CLKS = 16,
    parameter int LOAD_CLK  = 15,
    parameter int GUARD_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rise,
    input  logic start_lvl,
    input  logic ck_lvl,
    input  logic ck_fall,
    input  logic int_tick,
    output logic kick,
    output logic load,
    output logic hold,
    output logic stat
);
    localparam int FW = $clog2(CONV_CLKS + 1);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [FW-1:0] LOAD_LAST = FW'(LOAD_CLK - 1);
    localparam logic [FW-1:0] CONV_LAST = FW'(CONV_CLKS - 1);
    localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYC - 1);

    seq_state_t    state_q, state_d;
    logic [FW-1:0] fcnt_q;
    logic [GW-1:0] gcnt_q;
    logic          ext_q;
    logic          eoc_q;
    logic          conv_fall;

    assign conv_fall = ext_q ? ck_fall : int_tick;
    assign kick      = (state_q == S_IDLE) && start_rise;
    assign load      = (state_q == S_CONV) && conv_fall && (fcnt_q == LOAD_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_rise) state_d = ck_lvl ? S_GUARD : S_CONV;
            S_GUARD: if (gcnt_q == GUARD_LAST) state_d = S_CONV;
            S_CONV:  if (conv_fall && fcnt_q == LOAD_LAST) state_d = S_TAIL;
            S_TAIL:  if (conv_fall && fcnt_q == CONV_LAST) state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // counters, source and mode latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q <= '0;
            gcnt_q <= '0;
            ext_q  <= 1'b0;
            eoc_q  <= 1'b0;
        end else begin
            if (kick) begin
                fcnt_q <= '0;
                gcnt_q <= '0;
                ext_q  <= ck_lvl;
            end else begin
                if (state_q == S_GUARD) gcnt_q <= gcnt_q + 1'b1;
                if ((state_q == S_CONV || state_q == S_TAIL) && conv_fall)
                    fcnt_q <= fcnt_q + 1'b1;
            end
            if (load) eoc_q <= start_lvl;
        end
    end

    // outputs
    always_comb begin
        hold = 1'b1;
        stat = 1'b1;
        unique case (state_q)
            S_IDLE:  begin hold = 1'b0; stat = eoc_q; end
            S_GUARD: stat = 1'b1;
            S_CONV:  stat = 1'b1;
            S_TAIL:  stat = 1'b0;
        endcase
    end

    AST_SRC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> $stable(ext_q)); // R2
    AST_FALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt_q <= FW'(CONV_CLKS)); // R3
    AST_GUARD_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GUARD) |=> (fcnt_q == '0)); // R8
    AST_STAT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !stat); // R5
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int DATA_W      = 14,
    parameter int CONV_CLKS   = 16,
    parameter int LOAD_CLK    = 15,
    parameter int INT_DIV     = 4,
    parameter int GUARD_CYC   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_start,
    input  logic              ckpin,
    input  logic [DATA_W-1:0] sample_code,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic              hold,
    output logic              stat,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    logic start_lvl, start_rise;
    logic ck_lvl, ck_fall;
    logic int_tick, kick, load;
    logic [DATA_W-1:0] data_q;

    adc_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_start_sync (
        .clk(clk), .rst_n(rst_n), .din(cnv_start),
        .level(start_lvl), .edge_det(start_rise)
    );

    adc_sync_edge #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_ck_sync (
        .clk(clk), .rst_n(rst_n), .din(ckpin),
        .level(ck_lvl), .edge_det(ck_fall)
    );

    adc_int_div #(.DIV(INT_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(kick), .tick(int_tick)
    );

    adc_seq_fsm #(
        .CONV_CLKS(CONV_CLKS), .LOAD_CLK(LOAD_CLK), .GUARD_CYC(GUARD_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_rise(start_rise), .start_lvl(start_lvl),
        .ck_lvl(ck_lvl), .ck_fall(ck_fall), .int_tick(int_tick),
        .kick(kick), .load(load), .hold(hold), .stat(stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= sample_code;
    end

    assign dout_oe = ~cs_n & ~rd_n;
    assign dout    = dout_oe ? data_q : '0;

    AST_HOLD_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(start_rise)); // R1
    AST_DATA_ONLY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> $past(hold)); // R4
endmodule

// File: tb/sim_adc_conv_seq.sv
module sim_adc_conv_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_start = 1'b0;
    logic        ckpin = 1'b0;
    logic [13:0] code = '0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        hold, stat, dout_oe;
    logic [13:0] dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_conv_seq u0 (
        .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .ckpin(ckpin),
        .sample_code(code), .cs_n(cs_n), .rd_n(rd_n),
        .hold(hold), .stat(stat), .dout(dout), .dout_oe(dout_oe)
    );

    // bit 14 = end-of-conversion mode, bits 13:0 = code
    localparam logic [14:0] VEC [0:5] = '{
        {1'b0, 14'h1FFF}, {1'b1, 14'h2000}, {1'b0, 14'h0000},
        {1'b1, 14'h3FFF}, {1'b1, 14'h1555}, {1'b0, 14'h2AAA}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic read_bus(output logic [13:0] v, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #1;
        v = dout; oe = dout_oe;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // one internal-clock conversion, measured at falling edges
    task automatic conv_int(input logic [13:0] c, input bit eoc, input bit toggle,
                            input bit retrig, output int hl, output int sh, output int sl);
        int n;
        @(negedge clk);
        code = c; ckpin = 1'b0;
        repeat (3) @(negedge clk);
        cnv_start = 1'b1;
        hl = 0; sh = 0; sl = 0; n = 0;
        while (!hold) @(negedge clk);
        while (hold) begin
            hl++;
            if (stat) sh++; else sl++;
            n++;
            if (!eoc && !retrig && n == 2) cnv_start = 1'b0;
            if (retrig && n == 10) cnv_start = 1'b0;
            if (retrig && n == 20) cnv_start = 1'b1;
            if (toggle) ckpin = ~ckpin;
            @(negedge clk);
        end
        cnv_start = 1'b0; ckpin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int hl, sh, sl;
        logic [13:0] v;
        logic oe;

        // R12 reset state
        repeat (3) @(negedge clk);
        check(hold == 1'b0, "R12 hold in reset", hold, 0);
        check(stat == 1'b0, "R12 stat in reset", stat, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        read_bus(v, oe);
        check(v == 14'h0, "R12 data register after reset", v, 0);

        // R10 bus gating
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
        check(dout_oe == 1'b0 && dout == 14'h0, "R10 cs only", dout_oe, 0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        check(dout_oe == 1'b0 && dout == 14'h0, "R10 rd only", dout_oe, 0);
        rd_n = 1'b1;

        // vector table walk (R1 R3 R4 R5 R6 R11)
        for (int i = 0; i < 6; i++) begin
            conv_int(VEC[i][13:0], VEC[i][14], 1'b0, 1'b0, hl, sh, sl);
            check(hl == 64, "R3 R1 hold length", hl, 64);
            check(sh == 60, "R5 stat high length", sh, 60);
            check(sl == 4, "R6 stat low length", sl, 4);
            check(stat == VEC[i][14], "R5 R6 idle stat level", stat, VEC[i][14]);
            read_bus(v, oe);
            check(oe == 1'b1, "R10 bus enabled", oe, 1);
            check(v == VEC[i][13:0], "R4 R11 loaded code", v, VEC[i][13:0]);
            check(v[13] == VEC[i][13], "R11 sign bit", v[13], VEC[i][13]);
        end

        // R4 code changes before load used, after load not
        @(negedge clk); code = 14'h0123; ckpin = 1'b0;
        repeat (3) @(negedge clk); cnv_start = 1'b1;
        while (!hold) @(negedge clk);
        repeat (2) @(negedge clk); cnv_start = 1'b0;
        repeat (20) @(negedge clk); code = 14'h0456;
        while (stat) @(negedge clk);
        code = 14'h0789;
        while (hold) @(negedge clk);
        repeat (3) @(negedge clk);
        read_bus(v, oe);
        check(v == 14'h0456, "R4 value at fifteenth fall", v, 14'h0456);

        // R7 pin toggling with internal clock
        conv_int(14'h0ABC, 1'b0, 1'b1, 1'b0, hl, sh, sl);
        check(hl == 64, "R7 length with toggling pin", hl, 64);
        read_bus(v, oe);
        check(v == 14'h0ABC, "R7 result with toggling pin", v, 14'h0ABC);

        // R9 restart during conversion ignored
        conv_int(14'h1234, 1'b1, 1'b0, 1'b1, hl, sh, sl);
        check(hl == 64, "R9 length with mid restart", hl, 64);
        begin
            int seen = 0;
            repeat (20) begin @(negedge clk); if (hold) seen++; end
            check(seen == 0, "R9 no second conversion", seen, 0);
        end

        // R2 R8 external clock
        @(negedge clk); code = 14'h2D2D; ckpin = 1'b1;
        repeat (4) @(negedge clk); cnv_start = 1'b1;
        while (!hold) @(negedge clk);
        ckpin = 1'b0;                   // early fall inside guard window
        @(negedge clk); ckpin = 1'b1;
        @(negedge clk); cnv_start = 1'b0;
        repeat (80) @(negedge clk);
        check(hold == 1'b1 && stat == 1'b1, "R2 external waits for pin falls", {hold, stat}, 3);
        for (int k = 1; k <= 16; k++) begin
            ckpin = 1'b0;
            repeat (4) @(negedge clk);
            if (k == 14) check(stat == 1'b1, "R8 no load after 14 counted falls", stat, 1);
            if (k == 15) begin
                check(stat == 1'b0, "R2 R4 load on fifteenth external fall", stat, 0);
                read_bus(v, oe);
                check(v == 14'h2D2D, "R2 external loaded code", v, 14'h2D2D);
            end
            if (k == 15) check(hold == 1'b1, "R3 hold before sixteenth fall", hold, 1);
            ckpin = 1'b1;
            repeat (4) @(negedge clk);
        end
        check(hold == 1'b0, "R3 hold released after sixteenth fall", hold, 0);
        ckpin = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule